// File: doc/BRIEF.md
# Exception Pend and Priority Arbiter

This block keeps the pending and active state of a small, fixed set of exception sources and decides, cycle by cycle, which handler the processor should be running. The sources are a hard fault, a supervisor call, a software-pended context-switch request, a periodic tick and `NUM_IRQ` external interrupt lines. Every source except the hard fault has a priority level that is written through a small configuration port. The same port also carries the software pend bit for the context switch.

When a pending source is more urgent than the current execution priority, the block accepts it. It reports the accepted exception number with a one-cycle strobe and updates the current exception number and the execution priority. A handler-exit strobe retires the running handler. In the same clock edge, the block resumes the preempted handler, chains straight into an eligible pending handler, or drops back to thread level. A supervisor call that would have to wait is turned into a hard fault instead. Stacking, vector fetch and instruction execution belong to the surrounding core.

Exception numbers are fixed: 0 is thread level (no handler), 1 is hard fault, 2 is supervisor call, 3 is context switch, 4 is tick, and 5 up to 4+`NUM_IRQ` are the external lines in index order. The block assumes that software does not reprogram the priority of a source while that source is active.

Top module: `exc_pend_arbiter`

## Requirements
- R1: After synchronous reset, or one cycle after it, nothing is pending or active. `cur_num` is 0, `exec_prio` is the thread level 2^(PRIO_W+1)-1 (15 by default), `take_valid` is low, and all configurable priority levels are 0.
- R2: A request pulse makes its source pending at the next edge. The source is accepted at the following edge when its effective priority is strictly below `exec_prio`. The effective priority is the programmed level plus 1, or 0 for hard fault. On acceptance, `take_valid` pulses for one cycle and `take_num`, `cur_num` and `exec_prio` show the accepted source and its effective priority.
- R3: Among pending sources, the lowest effective priority wins. On a tie, the lower exception number wins.
- R4: A pending source preempts a running handler only when it is strictly more urgent. An equal or less urgent source waits.
- R5: On a handler-exit strobe, the current handler's active bit clears. The most urgent remaining active handler becomes current, and `exec_prio` takes that handler's priority.
- R6: If a pending source beats the priority of what remains after an exit, it is accepted on that same edge. `cur_num` moves straight to it, with no intermediate cycle at thread level or in the old handler.
- R7: When the last handler exits and nothing eligible is pending, `cur_num` returns to 0 and `exec_prio` returns to the thread level.
- R8: A configuration write to address 0 with data bit 0 set pends the context switch. A write there with bit 0 clear has no effect. At the lowest priority, the context switch runs only after every other handler has exited.
- R9: A supervisor-call pulse whose effective priority is not strictly below `exec_prio` pends the hard fault instead. The supervisor call itself does not become pending.
- R10: The hard fault has effective priority 0. It preempts a handler at any configured level, including level 0. Configuration writes to address 1 store nothing.
- R11: A source that requests again while it is active becomes pending again. It is chained in on the exit of its current instance.
- R12: A handler-exit strobe while at thread level changes nothing.
- R13: Configuration writes to addresses 2 to 4+`NUM_IRQ` set the priority level of that exception number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| svc_req | input | 1 | Supervisor-call request pulse |
| tick_req | input | 1 | Periodic tick request pulse |
| irq_req | input | NUM_IRQ | External interrupt request pulses, bit i is exception 5+i |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | NUM_W | Configuration address (0 pend bit, otherwise exception number) |
| cfg_wdata | input | PRIO_W | Write data: priority level, or bit 0 as context-switch pend |
| exit_strobe | input | 1 | Current handler has exited |
| take_valid | output | 1 | One-cycle strobe: an exception was accepted |
| take_num | output | NUM_W | Number of the exception accepted on the strobe |
| cur_num | output | NUM_W | Exception now running, 0 at thread level |
| exec_prio | output | PRIO_W+1 | Current execution priority (effective encoding) |

## Verification
The checker watches, on every cycle, the rules that hold for any input sequence. A hard fault always runs at priority 0. Thread level and priority 15 always go together. Any acceptance that does not coincide with an exit strictly lowers the execution priority. The execution priority does not move unless an exception is accepted, a handler exits or a configuration write occurs. An exit at thread level stays at thread level unless an acceptance happens on that edge. Which source wins a tie, the resumption of a preempted handler, tail-chaining, deferral of the context switch, supervisor-call escalation and re-pending of an active source all depend on particular sequences. Only the bench's scenario table and directed tests show those behaviours.

// File: rtl/exc_arb_pkg.sv
// Package: exception numbering shared by the arbiter and its submodules.
// Assumes exception numbers are small positive integers and 0 means thread level.
package exc_arb_pkg;
    localparam int EXC_THREAD    = 0;
    localparam int EXC_HARDFAULT = 1;
    localparam int EXC_SVCALL    = 2;
    localparam int EXC_CTXSW     = 3;
    localparam int EXC_TICK      = 4;
    localparam int EXC_IRQ_BASE  = 5;
    localparam int CFG_PEND_ADDR = 0;
endpackage

// File: rtl/exc_prio_regs.sv
// Module: exc_prio_regs
// Holds the programmable priority level of each configurable exception.
// It presents every source's effective priority: hard fault is 0, a configurable
// source is its level plus 1, and slot 0 (thread) is all ones.
// It also decodes the software pend write for the context switch.
// Assumes: EXT_W = PRIO_W + 1, so all ones is above every configurable level.
module exc_prio_regs
    import exc_arb_pkg::*;
#(
    parameter int NUM_EXC = 9,
    parameter int NUM_W   = 4,
    parameter int PRIO_W  = 3,
    parameter int EXT_W   = PRIO_W + 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_we,
    input  logic [NUM_W-1:0]               cfg_addr,
    input  logic [PRIO_W-1:0]              cfg_wdata,
    output logic [NUM_EXC-1:0][EXT_W-1:0]  prio_ext,
    output logic                           ctx_pend_set
);

    // Software pend decode: a write of bit0 = 1 to the pend address.
    assign ctx_pend_set = cfg_we && (cfg_addr == NUM_W'(CFG_PEND_ADDR)) && cfg_wdata[0];

    for (genvar g = 0; g < NUM_EXC; g++) begin : g_slot
        if (g == EXC_THREAD) begin : g_thr
            assign prio_ext[g] = '1;
        end else if (g == EXC_HARDFAULT) begin : g_hf
            assign prio_ext[g] = '0;
        end else begin : g_cfg
            logic [PRIO_W-1:0] lvl_q;

            // Priority level storage for this exception number.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lvl_q <= '0;
                end else if (cfg_we && (cfg_addr == NUM_W'(g))) begin
                    lvl_q <= cfg_wdata;
                end
            end

            assign prio_ext[g] = EXT_W'(lvl_q) + EXT_W'(1);
        end
    end

endmodule

// File: rtl/exc_pick.sv
// Module: exc_pick
// Finds, among the flagged entries, the one with the lowest priority value.
// On a tie, the lowest index wins.
// Purely combinational, with a linear scan; N is expected to be small (tens).
module exc_pick #(
    parameter int N     = 9,
    parameter int IDX_W = 4,
    parameter int W     = 4
) (
    input  logic [N-1:0]         req,
    input  logic [N-1:0][W-1:0]  prio,
    output logic                 found,
    output logic [IDX_W-1:0]     idx,
    output logic [W-1:0]         best
);

    // Scan upward; strict less-than keeps the lower index on ties.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '1;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || (prio[i] < best))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = prio[i];
            end
        end
    end

endmodule

// File: rtl/exc_req_map.sv
// Module: exc_req_map
// Turns the request pulses into a per-exception pend-set mask.
// A supervisor call that is not strictly more urgent than the current execution
// priority is redirected to the hard fault bit.
// Assumes: exec_prio is the registered execution priority of this cycle.
module exc_req_map
    import exc_arb_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int NUM_EXC = EXC_IRQ_BASE + NUM_IRQ,
    parameter int EXT_W   = 4
) (
    input  logic               svc_req,
    input  logic               tick_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               ctx_pend_set,
    input  logic [EXT_W-1:0]   svc_prio,
    input  logic [EXT_W-1:0]   exec_prio,
    output logic [NUM_EXC-1:0] set_mask
);

    logic svc_can_run;

    assign svc_can_run = svc_prio < exec_prio;

    // Build the pend-set mask from each request source.
    always_comb begin
        set_mask                = '0;
        set_mask[EXC_HARDFAULT] = svc_req && !svc_can_run;
        set_mask[EXC_SVCALL]    = svc_req && svc_can_run;
        set_mask[EXC_CTXSW]     = ctx_pend_set;
        set_mask[EXC_TICK]      = tick_req;
        for (int i = 0; i < NUM_IRQ; i++) begin
            set_mask[EXC_IRQ_BASE + i] = irq_req[i];
        end
    end

endmodule

// File: rtl/exc_pend_arbiter.sv
// Module: exc_pend_arbiter (top)
// Tracks the pending and active sets. It accepts the most urgent pending exception
// when that exception beats the execution priority, and it retires the current
// handler on exit_strobe. Resume, tail-chain or the return to thread level is
// resolved in the same edge as the exit.
// Assumes: the priority of an active source is not rewritten while it is active,
// so the most urgent active handler is always the one most recently entered.
module exc_pend_arbiter
    import exc_arb_pkg::*;
#(
    parameter int NUM_IRQ = 4,
    parameter int PRIO_W  = 3,
    parameter int NUM_EXC = EXC_IRQ_BASE + NUM_IRQ,
    parameter int NUM_W   = $clog2(NUM_EXC),
    parameter int EXT_W   = PRIO_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               svc_req,
    input  logic               tick_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               cfg_we,
    input  logic [NUM_W-1:0]   cfg_addr,
    input  logic [PRIO_W-1:0]  cfg_wdata,
    input  logic               exit_strobe,
    output logic               take_valid,
    output logic [NUM_W-1:0]   take_num,
    output logic [NUM_W-1:0]   cur_num,
    output logic [EXT_W-1:0]   exec_prio
);

    localparam logic [EXT_W-1:0] THREAD_PRIO = '1;

    logic [NUM_EXC-1:0][EXT_W-1:0] prio_ext;
    logic                          ctx_pend_set;
    logic [NUM_EXC-1:0]            set_mask;
    logic [NUM_EXC-1:0]            pending_q, active_q;
    logic [NUM_W-1:0]              cur_q, take_num_q;
    logic [EXT_W-1:0]              prio_q;
    logic                          take_q;

    logic [NUM_EXC-1:0]            cur_mask, act_after, take_mask;
    logic                          base_found, win_found, take;
    logic [NUM_W-1:0]              base_idx, win_idx;
    logic [EXT_W-1:0]              base_best, win_best, base_prio;

    exc_prio_regs #(
        .NUM_EXC (NUM_EXC),
        .NUM_W   (NUM_W),
        .PRIO_W  (PRIO_W),
        .EXT_W   (EXT_W)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .prio_ext     (prio_ext),
        .ctx_pend_set (ctx_pend_set)
    );

    exc_req_map #(
        .NUM_IRQ (NUM_IRQ),
        .NUM_EXC (NUM_EXC),
        .EXT_W   (EXT_W)
    ) u_map (
        .svc_req      (svc_req),
        .tick_req     (tick_req),
        .irq_req      (irq_req),
        .ctx_pend_set (ctx_pend_set),
        .svc_prio     (prio_ext[EXC_SVCALL]),
        .exec_prio    (prio_q),
        .set_mask     (set_mask)
    );

    // One-hot of the running exception, used to retire it on exit.
    always_comb begin
        for (int i = 0; i < NUM_EXC; i++) begin
            cur_mask[i] = (cur_q == NUM_W'(i));
        end
    end

    // Active set as it stands once this cycle's exit, if any, is applied.
    assign act_after = exit_strobe ? (active_q & ~cur_mask) : active_q;

    // Most urgent handler left running: the base the pending winner must beat.
    exc_pick #(
        .N     (NUM_EXC),
        .IDX_W (NUM_W),
        .W     (EXT_W)
    ) u_base (
        .req   (act_after),
        .prio  (prio_ext),
        .found (base_found),
        .idx   (base_idx),
        .best  (base_best)
    );

    // Most urgent pending request, with ties to the lower number.
    exc_pick #(
        .N     (NUM_EXC),
        .IDX_W (NUM_W),
        .W     (EXT_W)
    ) u_win (
        .req   (pending_q),
        .prio  (prio_ext),
        .found (win_found),
        .idx   (win_idx),
        .best  (win_best)
    );

    assign base_prio = base_found ? base_best : THREAD_PRIO;
    assign take      = win_found && (win_best < base_prio);

    // One-hot of the exception accepted in this cycle.
    always_comb begin
        for (int i = 0; i < NUM_EXC; i++) begin
            take_mask[i] = take && (win_idx == NUM_W'(i));
        end
    end

    // Pending and active bookkeeping; a new request outranks the clear on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
            active_q  <= '0;
        end else begin
            pending_q <= (pending_q & ~take_mask) | set_mask;
            active_q  <= act_after | take_mask;
        end
    end

    // Current handler, execution priority and acceptance strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q      <= '0;
            prio_q     <= THREAD_PRIO;
            take_q     <= 1'b0;
            take_num_q <= '0;
        end else begin
            take_q     <= take;
            take_num_q <= take ? win_idx : '0;
            if (take) begin
                cur_q  <= win_idx;
                prio_q <= win_best;
            end else begin
                cur_q  <= base_found ? base_idx : NUM_W'(EXC_THREAD);
                prio_q <= base_prio;
            end
        end
    end

    assign take_valid = take_q;
    assign take_num   = take_num_q;
    assign cur_num    = cur_q;
    assign exec_prio  = prio_q;

endmodule

// File: rtl/exc_pend_arbiter_chk.sv
// Module: exc_pend_arbiter_chk
// Checks port-level rules of the arbiter on every clock edge.
// It is attached to every instance of the top module by the bind below.
module exc_pend_arbiter_chk #(
    parameter int NUM_W = 4,
    parameter int EXT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic             exit_strobe,
    input logic             take_valid,
    input logic [NUM_W-1:0] take_num,
    input logic [NUM_W-1:0] cur_num,
    input logic [EXT_W-1:0] exec_prio
);

    localparam logic [EXT_W-1:0] THREAD_P = '1;

    // R2
    take_names_current_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_valid |-> (take_num == cur_num) && (cur_num != '0));

    // R7
    thread_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_num == '0) == (exec_prio == THREAD_P));

    // R10
    hardfault_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_num == NUM_W'(1)) |-> (exec_prio == '0));

    // R4
    preempt_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take_valid && !$past(exit_strobe)) |-> (exec_prio < $past(exec_prio)));

    // R5
    prio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_valid && !$past(exit_strobe) && !$past(cfg_we)) |-> $stable(exec_prio));

    // R12
    thread_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_strobe && (cur_num == '0)) |=> ((cur_num == '0) || take_valid));

endmodule

bind exc_pend_arbiter exc_pend_arbiter_chk #(
    .NUM_W (NUM_W),
    .EXT_W (EXT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .exit_strobe (exit_strobe),
    .take_valid  (take_valid),
    .take_num    (take_num),
    .cur_num     (cur_num),
    .exec_prio   (exec_prio)
);

// File: tb/tb_exc_pend_arbiter.sv
`timescale 1ns/1ps
// Bench for exc_pend_arbiter with default parameters (4 external lines, 3-bit levels).
// A scenario table is walked first, then directed tests for reset and ties.
module tb_exc_pend_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       svc_req = 1'b0, tick_req = 1'b0;
    logic [3:0] irq_req = '0;
    logic       cfg_we = 1'b0;
    logic [3:0] cfg_addr = '0;
    logic [2:0] cfg_wdata = '0;
    logic       exit_strobe = 1'b0;
    logic       take_valid;
    logic [3:0] take_num, cur_num, exec_prio;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    exc_pend_arbiter dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .svc_req     (svc_req),
        .tick_req    (tick_req),
        .irq_req     (irq_req),
        .cfg_we      (cfg_we),
        .cfg_addr    (cfg_addr),
        .cfg_wdata   (cfg_wdata),
        .exit_strobe (exit_strobe),
        .take_valid  (take_valid),
        .take_num    (take_num),
        .cur_num     (cur_num),
        .exec_prio   (exec_prio)
    );

    // Vector layout: [31:28] req tag, [27] svc, [26] tick, [25:22] irq, [21] we,
    // [20:17] addr, [16:14] wdata, [13] exit, [12] exp take, [11:8] exp cur, [7:4] exp prio.
    function automatic logic [31:0] mkv(input int rq, input bit sv, input bit tk,
                                        input logic [3:0] iq, input bit we,
                                        input logic [3:0] ad, input logic [2:0] wd,
                                        input bit ex, input bit tv,
                                        input logic [3:0] cu, input logic [3:0] pr);
        return {4'(rq), sv, tk, iq, we, ad, wd, ex, tv, cu, pr, 4'h0};
    endfunction

    localparam int NV = 35;
    localparam logic [31:0] VECS [NV] = '{
        // R13: program levels: svc 1, ctx 7, tick 2, irq0 4, irq1 4, irq2 3, irq3 5
        mkv(13, 0,0,4'b0000, 1,4'd2,3'd1, 0, 0,4'd0,4'd15),
        mkv(13, 0,0,4'b0000, 1,4'd3,3'd7, 0, 0,4'd0,4'd15),
        mkv(13, 0,0,4'b0000, 1,4'd4,3'd2, 0, 0,4'd0,4'd15),
        mkv(13, 0,0,4'b0000, 1,4'd5,3'd4, 0, 0,4'd0,4'd15),
        mkv(13, 0,0,4'b0000, 1,4'd6,3'd4, 0, 0,4'd0,4'd15),
        mkv(13, 0,0,4'b0000, 1,4'd7,3'd3, 0, 0,4'd0,4'd15),
        mkv(13, 0,0,4'b0000, 1,4'd8,3'd5, 0, 0,4'd0,4'd15),
        // R2: irq0 and irq1 request together; R3: tie goes to exception 5
        mkv(2,  0,0,4'b0011, 0,4'd0,3'd0, 0, 0,4'd0,4'd15),
        mkv(3,  0,0,4'b0000, 0,4'd0,3'd0, 0, 1,4'd5,4'd5),
        // R4: tick (prio 3) preempts irq0 (prio 5)
        mkv(4,  0,1,4'b0000, 0,4'd0,3'd0, 0, 0,4'd5,4'd5),
        mkv(4,  0,0,4'b0000, 0,4'd0,3'd0, 0, 1,4'd4,4'd3),
        // R5: tick exits, irq0 resumes; irq1 equal priority stays pending
        mkv(5,  0,0,4'b0000, 0,4'd0,3'd0, 1, 0,4'd5,4'd5),
        // R6: irq0 exits, irq1 chained in on the same edge
        mkv(6,  0,0,4'b0000, 0,4'd0,3'd0, 1, 1,4'd6,4'd5),
        // R7: last handler exits with nothing pending
        mkv(7,  0,0,4'b0000, 0,4'd0,3'd0, 1, 0,4'd0,4'd15),
        // R8: svc and software pend of ctx together; svc wins, ctx deferred
        mkv(8,  1,0,4'b0000, 1,4'd0,3'd1, 0, 0,4'd0,4'd15),
        mkv(8,  0,0,4'b0000, 0,4'd0,3'd0, 0, 1,4'd2,4'd2),
        mkv(8,  0,0,4'b0000, 0,4'd0,3'd0, 0, 0,4'd2,4'd2),
        mkv(8,  0,0,4'b0000, 0,4'd0,3'd0, 1, 1,4'd3,4'd8),
        mkv(7,  0,0,4'b0000, 0,4'd0,3'd0, 1, 0,4'd0,4'd15),
        // R9: tick reprogrammed to level 0, svc raised inside tick handler escalates
        mkv(13, 0,0,4'b0000, 1,4'd4,3'd0, 0, 0,4'd0,4'd15),
        mkv(2,  0,1,4'b0000, 0,4'd0,3'd0, 0, 0,4'd0,4'd15),
        mkv(2,  0,0,4'b0000, 0,4'd0,3'd0, 0, 1,4'd4,4'd1),
        mkv(9,  1,0,4'b0000, 0,4'd0,3'd0, 0, 0,4'd4,4'd1),
        // R10: hard fault preempts a level-0 handler
        mkv(10, 0,0,4'b0000, 0,4'd0,3'd0, 0, 1,4'd1,4'd0),
        mkv(5,  0,0,4'b0000, 0,4'd0,3'd0, 1, 0,4'd4,4'd1),
        // R9: svc was not left pending
        mkv(9,  0,0,4'b0000, 0,4'd0,3'd0, 1, 0,4'd0,4'd15),
        // R11: irq2 re-requested while active, chained in on exit
        mkv(2,  0,0,4'b0100, 0,4'd0,3'd0, 0, 0,4'd0,4'd15),
        mkv(2,  0,0,4'b0000, 0,4'd0,3'd0, 0, 1,4'd7,4'd4),
        mkv(11, 0,0,4'b0100, 0,4'd0,3'd0, 0, 0,4'd7,4'd4),
        mkv(11, 0,0,4'b0000, 0,4'd0,3'd0, 0, 0,4'd7,4'd4),
        mkv(11, 0,0,4'b0000, 0,4'd0,3'd0, 1, 1,4'd7,4'd4),
        mkv(7,  0,0,4'b0000, 0,4'd0,3'd0, 1, 0,4'd0,4'd15),
        // R12: exit at thread level
        mkv(12, 0,0,4'b0000, 0,4'd0,3'd0, 1, 0,4'd0,4'd15),
        // R8: pend write with bit 0 clear does nothing
        mkv(8,  0,0,4'b0000, 1,4'd0,3'd6, 0, 0,4'd0,4'd15),
        mkv(8,  0,0,4'b0000, 0,4'd0,3'd0, 0, 0,4'd0,4'd15)
    };

    // Compare the outputs against the expected triple; one vector per call.
    task automatic check(input int rq, input bit tv, input logic [3:0] cu, input logic [3:0] pr);
        n_vec++;
        if (take_valid !== tv || cur_num !== cu || exec_prio !== pr ||
            (tv && take_num !== cu)) begin
            n_fail++;
            $display("FAIL R%0d: take=%0b num=%0d cur=%0d prio=%0d, expected take=%0b cur=%0d prio=%0d",
                     rq, take_valid, take_num, cur_num, exec_prio, tv, cu, pr);
        end
    endtask

    // Drive one vector just after a falling edge, then sample at the next falling edge.
    task automatic apply(input logic [31:0] v);
        svc_req     = v[27];
        tick_req    = v[26];
        irq_req     = v[25:22];
        cfg_we      = v[21];
        cfg_addr    = v[20:17];
        cfg_wdata   = v[16:14];
        exit_strobe = v[13];
        @(posedge clk);
        @(negedge clk);
        svc_req = 0; tick_req = 0; irq_req = '0; cfg_we = 0; exit_strobe = 0;
        check(int'(v[31:28]), v[12], v[11:8], v[7:4]);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check(1, 0, 4'd0, 4'd15);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
        end

        // R1: reset mid-run clears a pending request and the levels
        apply(mkv(2, 0,0,4'b1000, 0,4'd0,3'd0, 0, 0,4'd0,4'd15));
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        apply(mkv(1, 0,0,4'b0000, 0,4'd0,3'd0, 0, 0,4'd0,4'd15));
        // R3: after reset all levels are 0; irq1 and irq3 tie, exception 6 wins
        apply(mkv(3, 0,0,4'b1010, 0,4'd0,3'd0, 0, 0,4'd0,4'd15));
        apply(mkv(3, 0,0,4'b0000, 0,4'd0,3'd0, 0, 1,4'd6,4'd1));
        // R6: exit of exception 6 chains the waiting exception 8
        apply(mkv(6, 0,0,4'b0000, 0,4'd0,3'd0, 1, 1,4'd8,4'd1));
        apply(mkv(7, 0,0,4'b0000, 0,4'd0,3'd0, 1, 0,4'd0,4'd15));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule